// File: doc/BRIEF.md
# Stepper Driver Fault and Power Supervisor

This block decides, cycle by cycle, whether the power bridge of a stepper motor driver may conduct, whether the step sequencer must be held at or sent back to its home position, and whether step commands are accepted. It takes the digital pins of the driver and the flags of the analog protection detectors, and it produces four levels for the rest of the driver. The analog detectors are not part of the block. Only their logic flags enter it.

Every pin and flag is asynchronous. Each passes through a two-stage synchroniser before any decision uses it. Faults fall into two groups. Over-temperature and charge-pump undervoltage block the outputs only while they are present. A short to ground is latched, and only a wake-up from sleep or a removal of logic power (the block reset) clears it. The enable pin gates only the outputs: step acceptance and the home state are unaffected by it. After the sleep pin releases, step acceptance stays off for a parameterised number of clock cycles so that the charge pump can settle. The default is 1 ms at 250 MHz.

Top module: `drv_supervisor`

## Requirements
- R1: With `en_n_i` high, `out_allow_o` is 0 while `step_accept_o` and `home_o` keep the values they would have with `en_n_i` low.
- R2: With `reset_n_i` low, `home_o` is 1 and both `step_accept_o` and `out_allow_o` are 0. Once it returns high, step acceptance resumes.
- R3: A pulse on `stg_i` at least two clock cycles wide sets `fault_latched_o` to 1 and forces `out_allow_o` to 0. The latch holds after the pulse has ended, and toggling `en_n_i`, pulsing `reset_n_i` low or asserting `ovt_i` does not clear it.
- R4: The latch is cleared only by the rising edge of `sleep_n_i` after a low period, or by `rst_n`. Holding `sleep_n_i` low alone does not clear it.
- R5: `ovt_i` or `cpuv_i` high forces `out_allow_o` to 0 only while the flag is high. Neither sets `fault_latched_o`, and outputs return once the flag drops.
- R6: `uvlo_i` high forces `out_allow_o` to 0, `home_o` to 1 and `step_accept_o` to 0.
- R7: With `sleep_n_i` low, `out_allow_o` and `step_accept_o` are 0.
- R8: After `sleep_n_i` rises, `step_accept_o` stays 0 through the first WAKE_CYC+2 rising clock edges and becomes 1 after edge WAKE_CYC+3. This is two synchroniser stages, one edge-detect cycle and WAKE_CYC count cycles.
- R9: A rising `ovt_i`, or the setting of the short-to-ground latch, drives `home_o` high for exactly one clock cycle.
- R10: A change on a level input appears on the outputs after the second rising clock edge and not after the first.
- R11: While `rst_n` is low: `out_allow_o`=0, `home_o`=1, `step_accept_o`=0, `fault_latched_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; models logic power removal |
| en_n_i | input | 1 | Active-low output enable pin |
| sleep_n_i | input | 1 | Active-low sleep pin |
| reset_n_i | input | 1 | Active-low sequencer reset pin |
| uvlo_i | input | 1 | Logic supply undervoltage flag |
| ovt_i | input | 1 | Over-temperature flag |
| cpuv_i | input | 1 | Charge-pump undervoltage flag |
| stg_i | input | 1 | Short-to-ground detect pulse |
| out_allow_o | output | 1 | Bridge outputs may conduct |
| home_o | output | 1 | Force step sequencer to home position |
| step_accept_o | output | 1 | Step edges are accepted by the sequencer |
| fault_latched_o | output | 1 | Short-to-ground fault is latched |

## Verification
The hardest situation to reach from the ports is the clearing of a latched short-to-ground fault. Only a low-then-high sleep sequence clears it, and the stimulus first latches a fault and then tries every non-clearing input (enable, reset pin, over-temperature, a held sleep low) before it releases sleep. The end of the wake window is checked on the exact edge, on both sides, with a shortened count. The single-cycle home pulse is counted over a window rather than sampled, so that a stretched or repeated pulse is also caught.

// File: rtl/drv_supervisor_pkg.sv
package drv_supervisor_pkg;
  // Positions of the asynchronous inputs inside the synchroniser bank.
  localparam int unsigned SYN_EN_N    = 0;
  localparam int unsigned SYN_SLEEP_N = 1;
  localparam int unsigned SYN_RESET_N = 2;
  localparam int unsigned SYN_UVLO    = 3;
  localparam int unsigned SYN_OVT     = 4;
  localparam int unsigned SYN_CPUV    = 5;
  localparam int unsigned SYN_STG     = 6;
  localparam int unsigned SYN_NUM     = 7;

  // Safe values loaded into every synchroniser stage during reset:
  // outputs disabled, asleep, sequencer held home, undervoltage present.
  localparam logic [SYN_NUM-1:0] SYN_SAFE = 7'b000_1001;
endpackage

// File: rtl/drv_sync_bank.sv
module drv_sync_bank #(
  parameter int unsigned        WIDTH   = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[b]}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/drv_wake_timer.sv
module drv_wake_timer #(
  parameter int unsigned WAKE_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake_i,
  output logic wake_edge_o,
  output logic ready_o
);
  localparam int unsigned CW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYC);

  logic          awake_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign wake_edge_o = awake_i & ~awake_q;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!awake_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (wake_edge_o) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake_q <= 1'b0;
    end else begin
      awake_q <= awake_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o = awake_i & ~wake_edge_o & (cnt_q == '0);
endmodule

// File: rtl/drv_fault_latch.sv
module drv_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic stg_i,
  input  logic ovt_i,
  input  logic wake_edge_i,
  output logic fault_o,
  output logic home_pulse_o
);
  logic fault_q;
  logic fault_d;
  logic ovt_q;
  logic pulse_q;
  logic pulse_d;
  logic set_evt;

  always_comb begin
    set_evt = stg_i & ~fault_q;
    // Setting wins over a wake edge in the same cycle.
    fault_d = stg_i | (fault_q & ~wake_edge_i);
    pulse_d = set_evt | (ovt_i & ~ovt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      ovt_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
      ovt_q   <= ovt_i;
      pulse_q <= pulse_d;
    end
  end

  assign fault_o      = fault_q;
  assign home_pulse_o = pulse_q;
endmodule

// File: rtl/drv_supervisor.sv
module drv_supervisor
  import drv_supervisor_pkg::*;
#(
  parameter int unsigned WAKE_CYC   = 250000,
  parameter int unsigned SYN_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n_i,
  input  logic sleep_n_i,
  input  logic reset_n_i,
  input  logic uvlo_i,
  input  logic ovt_i,
  input  logic cpuv_i,
  input  logic stg_i,
  output logic out_allow_o,
  output logic home_o,
  output logic step_accept_o,
  output logic fault_latched_o
);
  logic [SYN_NUM-1:0] raw;
  logic [SYN_NUM-1:0] syn;

  logic s_en_n, s_sleep_n, s_reset_n, s_uvlo, s_ovt, s_cpuv, s_stg;
  logic wake_edge, wake_ready, fault_q, home_pulse;

  always_comb begin
    raw              = '0;
    raw[SYN_EN_N]    = en_n_i;
    raw[SYN_SLEEP_N] = sleep_n_i;
    raw[SYN_RESET_N] = reset_n_i;
    raw[SYN_UVLO]    = uvlo_i;
    raw[SYN_OVT]     = ovt_i;
    raw[SYN_CPUV]    = cpuv_i;
    raw[SYN_STG]     = stg_i;
  end

  drv_sync_bank #(
    .WIDTH  (SYN_NUM),
    .STAGES (SYN_STAGES),
    .RST_VAL(SYN_SAFE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw),
    .sync_o (syn)
  );

  assign s_en_n    = syn[SYN_EN_N];
  assign s_sleep_n = syn[SYN_SLEEP_N];
  assign s_reset_n = syn[SYN_RESET_N];
  assign s_uvlo    = syn[SYN_UVLO];
  assign s_ovt     = syn[SYN_OVT];
  assign s_cpuv    = syn[SYN_CPUV];
  assign s_stg     = syn[SYN_STG];

  drv_wake_timer #(
    .WAKE_CYC(WAKE_CYC)
  ) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .awake_i    (s_sleep_n),
    .wake_edge_o(wake_edge),
    .ready_o    (wake_ready)
  );

  drv_fault_latch u_fault (
    .clk         (clk),
    .rst_n       (rst_n),
    .stg_i       (s_stg),
    .ovt_i       (s_ovt),
    .wake_edge_i (wake_edge),
    .fault_o     (fault_q),
    .home_pulse_o(home_pulse)
  );

  logic seq_run;
  assign seq_run = s_reset_n & ~s_uvlo;

  assign out_allow_o     = ~s_en_n & s_sleep_n & seq_run & ~s_ovt & ~s_cpuv & ~fault_q;
  assign home_o          = ~seq_run | home_pulse;
  assign step_accept_o   = seq_run & wake_ready;
  assign fault_latched_o = fault_q;
endmodule

// File: rtl/drv_supervisor_chk.sv
module drv_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic s_sleep_n,
  input logic s_reset_n,
  input logic s_stg,
  input logic wake_edge,
  input logic home_pulse,
  input logic out_allow_o,
  input logic home_o,
  input logic step_accept_o,
  input logic fault_latched_o
);
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched_o && !wake_edge) |=> fault_latched_o);

  p_fault_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched_o |-> !out_allow_o);

  p_wake_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_edge && !s_stg) |=> !fault_latched_o);

  p_sleep_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s_sleep_n |-> (!out_allow_o && !step_accept_o));

  p_reset_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s_reset_n |-> (home_o && !step_accept_o));

  p_wake_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_edge |=> !step_accept_o);

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    home_pulse |=> !home_pulse);
endmodule

bind drv_supervisor drv_supervisor_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .s_sleep_n      (s_sleep_n),
  .s_reset_n      (s_reset_n),
  .s_stg          (s_stg),
  .wake_edge      (wake_edge),
  .home_pulse     (home_pulse),
  .out_allow_o    (out_allow_o),
  .home_o         (home_o),
  .step_accept_o  (step_accept_o),
  .fault_latched_o(fault_latched_o)
);

// File: tb/drv_supervisor_tb.sv
module drv_supervisor_tb;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n, en_n, sleep_n, reset_n, uvlo, ovt, cpuv, stg;
  logic out_allow, home, step_acc, fault;

  int errors = 0;
  int checks = 0;
  int home_cnt = 0;
  bit done = 1'b0;

  // Scoreboard queue: expected {out_allow, home, step_accept, fault}.
  logic [3:0] q_exp[$];
  string      q_tag[$];
  event       ev_push;

  always #2 clk = ~clk;

  drv_supervisor #(.WAKE_CYC(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_n_i(en_n), .sleep_n_i(sleep_n),
    .reset_n_i(reset_n), .uvlo_i(uvlo), .ovt_i(ovt), .cpuv_i(cpuv),
    .stg_i(stg), .out_allow_o(out_allow), .home_o(home),
    .step_accept_o(step_acc), .fault_latched_o(fault)
  );

  always @(negedge clk) if (home) home_cnt++;

  // Monitor: drains the queue and compares against the live outputs.
  initial begin
    forever begin
      @(ev_push);
      while (q_exp.size() != 0) begin
        logic [3:0] e;
        string t;
        logic [3:0] a;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = {out_allow, home, step_acc, fault};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual={allow,home,acc,fault}=%b expected=%b", t, a, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [3:0] e, input string t);
    q_exp.push_back(e);
    q_tag.push_back(t);
    -> ev_push;
    #1;
  endtask

  task automatic check_val(input int a, input int e, input string t);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", t, a, e);
    end
  endtask

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int h0;
    rst_n = 1'b0; en_n = 1'b0; sleep_n = 1'b1; reset_n = 1'b1;
    uvlo = 1'b0; ovt = 1'b0; cpuv = 1'b0; stg = 1'b0;
    tick(3);
    expect_out(4'b0100, "R11 power-on state");
    rst_n = 1'b1;
    tick(W + 6);
    expect_out(4'b1010, "R11 normal run after power-on");

    // R10 / R1: enable high.
    en_n = 1'b1;
    tick(1);
    expect_out(4'b1010, "R10 no change after one edge");
    tick(1);
    expect_out(4'b0010, "R10 change after second edge");
    tick(3);
    expect_out(4'b0010, "R1 enable high: outputs off, stepping kept");
    en_n = 1'b0;
    tick(4);
    expect_out(4'b1010, "R1 enable low restores outputs");

    // R2: reset pin.
    reset_n = 1'b0;
    tick(4);
    expect_out(4'b0100, "R2 reset pin low");
    reset_n = 1'b1;
    tick(4);
    expect_out(4'b1010, "R2 reset pin released");

    // R5: over-temperature with R9 single home pulse.
    h0 = home_cnt;
    ovt = 1'b1;
    tick(6);
    expect_out(4'b0010, "R5 over-temperature blocks outputs, no latch");
    check_val(home_cnt - h0, 1, "R9 home pulse cycles on over-temperature");
    ovt = 1'b0;
    tick(4);
    expect_out(4'b1010, "R5 over-temperature released");
    cpuv = 1'b1;
    tick(4);
    expect_out(4'b0010, "R5 charge-pump undervoltage blocks outputs");
    cpuv = 1'b0;
    tick(4);
    expect_out(4'b1010, "R5 charge-pump undervoltage released");

    // R6: undervoltage lockout.
    uvlo = 1'b1;
    tick(4);
    expect_out(4'b0100, "R6 undervoltage lockout");
    uvlo = 1'b0;
    tick(4);
    expect_out(4'b1010, "R6 undervoltage released");

    // R3: short-to-ground latch.
    h0 = home_cnt;
    stg = 1'b1;
    tick(2);
    stg = 1'b0;
    tick(6);
    expect_out(4'b0011, "R3 short latched after pulse");
    check_val(home_cnt - h0, 1, "R9 home pulse cycles on short latch");
    en_n = 1'b1; tick(4); en_n = 1'b0; tick(4);
    expect_out(4'b0011, "R3 enable toggle does not clear latch");
    reset_n = 1'b0; tick(4);
    expect_out(4'b0101, "R3 reset pin low keeps latch");
    reset_n = 1'b1; ovt = 1'b1; tick(4); ovt = 1'b0; tick(4);
    expect_out(4'b0011, "R3 reset pin and over-temperature do not clear latch");

    // R4 / R7: sleep held low keeps latch; wake clears it.
    sleep_n = 1'b0;
    tick(5);
    expect_out(4'b0001, "R7 sleep low blocks outputs and steps; R4 latch held");
    sleep_n = 1'b1;
    tick(W + 2);
    expect_out(4'b1000, "R8 step accept still low at edge W+2; R4 latch cleared");
    tick(1);
    expect_out(4'b1010, "R8 step accept high at edge W+3");

    // R4: block reset clears latch.
    stg = 1'b1; tick(2); stg = 1'b0; tick(4);
    expect_out(4'b0011, "R4 short latched again");
    rst_n = 1'b0;
    tick(2);
    expect_out(4'b0100, "R4 block reset clears latch");
    rst_n = 1'b1;
    tick(W + 6);
    expect_out(4'b1010, "R4 normal run after block reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule